// File: doc/BRIEF.md
# Underflow Interrupt Decimation Counter

This block thins out a stream of timer underflow strobes so that the processor sees only one interrupt request for every programmed number of events. A 4-bit divide value sets that number. It can be written at any time, but a write that would disturb a count in progress is refused and flagged. The block has two counting modes, chosen by a mode bit. In the plain mode, every underflow that arrives while the timer runs is counted. In the qualified mode, a second select bit decides which underflows count. Either only the underflows that coincide with a falling-edge strobe of the companion reload signal count, or only the underflows that arrive without such a strobe.

A three-state machine tracks the count. STOPPED holds while the run input is low. LEAD covers the span before the first interrupt. STEADY covers every later span. The transitions are:
- STOPPED to LEAD when run is high.
- LEAD to STEADY on the terminal qualifying event.
- LEAD to LEAD when a write is accepted.
- STEADY to LEAD when a write is accepted.
- LEAD or STEADY to STOPPED when run drops.

In the qualified mode with the reload-edge condition, the terminal value in LEAD is one less than the divide value. This makes the first interrupt arrive one event early.

Top module: `udc_top`

## Requirements
- R1: After reset, `irq` and `wr_err` are 0.
- R2: With `qual_mode`=0 and `run`=1, each `udf` strobe is one event, and `irq` fires on every nth event for a divide value n in 1..15.
- R3: `irq` is high for exactly one clock, in the cycle right after the clock edge that registers the terminal event.
- R4: With `qual_mode`=1 and `edge_sel`=0, only `udf` strobes with `rld_fall`=0 in the same cycle are counted.
- R5: With `qual_mode`=1 and `edge_sel`=1, only `udf` strobes with `rld_fall`=1 in the same cycle are counted. The first `irq` comes after n-1 counted events (after 1 when n=1), and each later one after n events.
- R6: While `run`=0, `udf` strobes are ignored and no `irq` is raised.
- R7: The event count is cleared when `run` rises and when a divide-value write is accepted.
- R8: A written value of 0 is used as 1, and `wr_err` pulses high in the cycle after the write.
- R9: With `qual_mode`=1 and `run`=1, a write is ignored (the old divide value and the count are kept), and `wr_err` pulses high in the cycle after it.
- R10: With `qual_mode`=0 and `run`=1, a write in the same cycle as `udf` is ignored and `wr_err` pulses. That underflow is still counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Timer running (1) or stopped (0) |
| udf | input | 1 | Timer underflow strobe, one cycle |
| rld_fall | input | 1 | Falling-edge strobe of the companion reload signal |
| qual_mode | input | 1 | 0: count every underflow; 1: count qualifying underflows |
| edge_sel | input | 1 | In qualified mode, 1: qualify on `rld_fall`; 0: qualify on its absence |
| wr_en | input | 1 | Divide-value write strobe |
| wr_data | input | 4 | Divide value to write |
| irq | output | 1 | Interrupt request pulse |
| wr_err | output | 1 | Pulse flagging a refused or out-of-range write |

## Verification
The assertions check on every cycle that:
- an interrupt pulse follows a counted underflow taken while running (R6);
- every error pulse traces back to a write;
- a write of zero is always flagged (R8);
- a write in qualified mode while running is always flagged (R9).

Only the bench scenarios can show that the pulse spacing matches the divide value in each mode, including the early first interrupt in the reload-edge mode. The same holds for the count clearing on a run restart or an accepted write, and for a refused write keeping the old divide value.

// File: rtl/udc_pkg.sv
package udc_pkg;
    typedef enum logic [1:0] {
        ST_STOPPED = 2'd0,
        ST_LEAD    = 2'd1,
        ST_STEADY  = 2'd2
    } udc_state_e;
endpackage

// File: rtl/udc_qualify.sv
module udc_qualify (
    input  logic run,
    input  logic udf,
    input  logic rld_fall,
    input  logic qual_mode,
    input  logic edge_sel,
    output logic evt,
    output logic offset_mode
);
    logic cond;

    always_comb begin
        if (!qual_mode)
            cond = 1'b1;
        else if (edge_sel)
            cond = rld_fall;
        else
            cond = !rld_fall;
        evt         = run && udf && cond;
        offset_mode = qual_mode && edge_sel;
    end
endmodule

// File: rtl/udc_wrguard.sv
module udc_wrguard #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          udf,
    input  logic          qual_mode,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] divisor,
    output logic          clr,
    output logic          wr_err
);
    localparam logic [DW-1:0] ONE = DW'(1);

    logic reject;
    logic zero_val;

    always_comb begin
        reject   = wr_en && run && (qual_mode || udf);
        zero_val = wr_en && (wr_data == '0);
        clr      = wr_en && !reject;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            divisor <= ONE;
            wr_err  <= 1'b0;
        end else begin
            if (clr)
                divisor <= zero_val ? ONE : wr_data;
            wr_err <= reject || zero_val;
        end
    end
endmodule

// File: rtl/udc_fsm.sv
module udc_fsm
    import udc_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          evt,
    input  logic          offset_mode,
    input  logic          clr,
    input  logic [DW-1:0] divisor,
    output logic          irq
);
    localparam logic [DW-1:0] ONE = DW'(1);

    udc_state_e    state, state_nx;
    logic [DW-1:0] cnt, cnt_nx;
    logic [DW-1:0] target;
    logic          hit;

    always_comb begin
        if (state == ST_LEAD && offset_mode && divisor > ONE)
            target = divisor - ONE;
        else
            target = divisor;
        hit = evt && ((cnt + ONE) == target);
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_STOPPED: begin
                if (run) begin
                    state_nx = ST_LEAD;
                    cnt_nx   = '0;
                end else if (clr) begin
                    cnt_nx = '0;
                end
            end
            ST_LEAD, ST_STEADY: begin
                if (!run) begin
                    state_nx = ST_STOPPED;
                end else if (clr) begin
                    state_nx = ST_LEAD;
                    cnt_nx   = '0;
                end else if (hit) begin
                    state_nx = ST_STEADY;
                    cnt_nx   = '0;
                end else if (evt) begin
                    cnt_nx = cnt + ONE;
                end
            end
            default: begin
                state_nx = ST_STOPPED;
                cnt_nx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_STOPPED;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= hit && (state != ST_STOPPED) && run && !clr;
    end
endmodule

// File: rtl/udc_top.sv
module udc_top #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          udf,
    input  logic          rld_fall,
    input  logic          qual_mode,
    input  logic          edge_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          irq,
    output logic          wr_err
);
    logic          evt;
    logic          offset_mode;
    logic          clr;
    logic [DW-1:0] divisor;

    udc_qualify u_qual (
        .run         (run),
        .udf         (udf),
        .rld_fall    (rld_fall),
        .qual_mode   (qual_mode),
        .edge_sel    (edge_sel),
        .evt         (evt),
        .offset_mode (offset_mode)
    );

    udc_wrguard #(.DW(DW)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .udf       (udf),
        .qual_mode (qual_mode),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .divisor   (divisor),
        .clr       (clr),
        .wr_err    (wr_err)
    );

    udc_fsm #(.DW(DW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .evt         (evt),
        .offset_mode (offset_mode),
        .clr         (clr),
        .divisor     (divisor),
        .irq         (irq)
    );
endmodule

// File: rtl/udc_checker.sv
module udc_checker #(
    parameter int DW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          udf,
    input logic          qual_mode,
    input logic          wr_en,
    input logic [DW-1:0] wr_data,
    input logic          irq,
    input logic          wr_err
);
    // R6: an interrupt needs an underflow taken while running
    p_irq_needs_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(run && udf));

    // R6: an underflow while stopped never produces an interrupt
    p_stopped_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && udf) |=> !irq);

    // R8, R9, R10: an error pulse always traces back to a write
    p_err_from_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en));

    // R8: a zero write is always flagged
    p_zero_flagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == '0) |=> wr_err);

    // R9: a qualified-mode write while running is always flagged
    p_qual_run_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && run && qual_mode) |=> wr_err);
endmodule

bind udc_top udc_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .udf       (udf),
    .qual_mode (qual_mode),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .irq       (irq),
    .wr_err    (wr_err)
);

// File: tb/udc_top_test.sv
module udc_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0, udf = 1'b0, rld_fall = 1'b0;
    logic       qual_mode = 1'b0, edge_sel = 1'b0, wr_en = 1'b0;
    logic [3:0] wr_data = 4'd0;
    logic       irq, wr_err;

    int n_chk = 0, n_bad = 0, irq_seen = 0;

    always #5 clk = ~clk;

    udc_top uut (
        .clk(clk), .rst_n(rst_n), .run(run), .udf(udf), .rld_fall(rld_fall),
        .qual_mode(qual_mode), .edge_sel(edge_sel), .wr_en(wr_en),
        .wr_data(wr_data), .irq(irq), .wr_err(wr_err)
    );

    always @(negedge clk) if (irq) irq_seen++;

    // fields: n[16:13] qual[12] sel[11] alt[10] events[9:4] expected irqs[3:0]
    localparam logic [16:0] VEC [7] = '{
        {4'd3,  1'b0, 1'b0, 1'b0, 6'd9,  4'd3},  // R2
        {4'd1,  1'b0, 1'b0, 1'b0, 6'd5,  4'd5},  // R2
        {4'd15, 1'b0, 1'b0, 1'b0, 6'd30, 4'd2},  // R2
        {4'd2,  1'b1, 1'b0, 1'b1, 6'd8,  4'd2},  // R4
        {4'd2,  1'b1, 1'b1, 1'b1, 6'd10, 4'd3},  // R5
        {4'd4,  1'b1, 1'b1, 1'b1, 6'd14, 4'd2},  // R5
        {4'd3,  1'b1, 1'b0, 1'b0, 6'd6,  4'd2}   // R4
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive one underflow, sample irq one cycle later, then idle one cycle
    task automatic ev(input logic fall, output logic got);
        @(negedge clk); udf = 1'b1; rld_fall = fall;
        @(negedge clk); udf = 1'b0; rld_fall = 1'b0; got = irq;
    endtask

    task automatic wr(input logic [3:0] d, input logic with_udf, output logic err, output logic got);
        @(negedge clk); wr_en = 1'b1; wr_data = d; udf = with_udf;
        @(negedge clk); wr_en = 1'b0; udf = 1'b0; err = wr_err; got = irq;
    endtask

    task automatic set_run(input logic r);
        @(negedge clk); run = r;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #1500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic g, e;
        int   k;
        repeat (3) @(negedge clk);
        check(irq == 1'b0 && wr_err == 1'b0, "R1", {irq, wr_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(irq == 1'b0 && wr_err == 1'b0, "R1", {irq, wr_err}, 0);

        // table walk
        for (int v = 0; v < 7; v++) begin
            set_run(1'b0);
            qual_mode = VEC[v][12]; edge_sel = VEC[v][11];
            wr(VEC[v][16:13], 1'b0, e, g);
            set_run(1'b1);
            irq_seen = 0;
            for (int i = 0; i < int'(VEC[v][9:4]); i++)
                ev(VEC[v][10] && (i % 2 == 1), g);
            @(negedge clk);
            check(irq_seen == int'(VEC[v][3:0]), v < 3 ? "R2" : (v == 4 || v == 5) ? "R5" : "R4",
                  irq_seen, int'(VEC[v][3:0]));
        end

        // R3: pulse timing and width
        set_run(1'b0); qual_mode = 1'b0; edge_sel = 1'b0;
        wr(4'd2, 1'b0, e, g); set_run(1'b1);
        ev(1'b0, g); check(g == 1'b0, "R3", g, 0);
        @(negedge clk); udf = 1'b1;
        @(negedge clk); udf = 1'b0;
        check(irq == 1'b1, "R3", irq, 1);
        @(negedge clk);
        check(irq == 1'b0, "R3", irq, 0);

        // R5: n=1 in reload-edge mode fires on every qualifying event
        set_run(1'b0); qual_mode = 1'b1; edge_sel = 1'b1;
        wr(4'd1, 1'b0, e, g); set_run(1'b1);
        ev(1'b1, g); check(g == 1'b1, "R5", g, 1);
        ev(1'b0, g); check(g == 1'b0, "R5", g, 0);
        ev(1'b1, g); check(g == 1'b1, "R5", g, 1);

        // R6: stopped timer ignores underflows
        set_run(1'b0); qual_mode = 1'b0; edge_sel = 1'b0;
        wr(4'd1, 1'b0, e, g);
        irq_seen = 0;
        for (int i = 0; i < 5; i++) ev(1'b0, g);
        check(irq_seen == 0, "R6", irq_seen, 0);

        // R7: run restart clears the count
        wr(4'd3, 1'b0, e, g); set_run(1'b1);
        ev(1'b0, g); ev(1'b0, g);
        set_run(1'b0); set_run(1'b1);
        ev(1'b0, g); ev(1'b0, g);
        check(g == 1'b0, "R7", g, 0);
        ev(1'b0, g); check(g == 1'b1, "R7", g, 1);

        // R7: accepted write while running clears the count
        ev(1'b0, g); ev(1'b0, g);
        wr(4'd3, 1'b0, e, g);
        check(e == 1'b0, "R7", e, 0);
        ev(1'b0, g); ev(1'b0, g);
        check(g == 1'b0, "R7", g, 0);
        ev(1'b0, g); check(g == 1'b1, "R7", g, 1);

        // R10: write colliding with an underflow is refused, underflow counted
        ev(1'b0, g); ev(1'b0, g);
        wr(4'd1, 1'b1, e, g);
        check(e == 1'b1, "R10", e, 1);
        check(g == 1'b1, "R10", g, 1);
        ev(1'b0, g); ev(1'b0, g);
        check(g == 1'b0, "R10", g, 0);
        ev(1'b0, g); check(g == 1'b1, "R10", g, 1);

        // R8: zero write acts as divide by one and is flagged
        set_run(1'b0);
        wr(4'd0, 1'b0, e, g);
        check(e == 1'b1, "R8", e, 1);
        set_run(1'b1);
        ev(1'b0, g); check(g == 1'b1, "R8", g, 1);
        ev(1'b0, g); check(g == 1'b1, "R8", g, 1);

        // R9: qualified mode, running: write refused, old value and count kept
        set_run(1'b0); qual_mode = 1'b1; edge_sel = 1'b0;
        wr(4'd2, 1'b0, e, g); set_run(1'b1);
        ev(1'b0, g);
        wr(4'd5, 1'b0, e, g);
        check(e == 1'b1, "R9", e, 1);
        ev(1'b0, g); check(g == 1'b1, "R9", g, 1);
        ev(1'b0, g); ev(1'b0, g);
        check(g == 1'b1, "R9", g, 1);

        k = 0;
        set_run(1'b0);
        check(wr_err == 1'b0 && k == 0, "R1", wr_err, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule